// File: doc/BRIEF.md
# Configurable I/O Cell Group

This block is a group of sixteen pad-side I/O cells. Each cell is given its own mode on a configuration field. It can pass its pin straight through as an input, capture the pin in a register, hold it in a level-sensitive latch, drive the pin as an output, or act as a bidirectional pin. Every cell hands one input bit to the global routing bus and drives its pin through a data line and a separate output-enable line. The tristate buffer itself sits outside the block.

Registered and latched inputs are timed by one of two dedicated I/O clocks, and a per-cell bit picks the clock. The output driver of a cell is enabled by one of several sources, chosen per cell:

- a product-term enable shared by the whole group,
- either of two global enables,
- a constant on.

Two group-wide controls override all of these and force every pin to high impedance. One is an active-low test enable. The other is a programming-mode request.

Top module: `iocg_group`

## Requirements
- R1: In mode code 0 (combinational input) a cell's route_in equals its pad_in in the same cycle, and pad_oe and pad_out are 0.
- R2: In mode code 1 (registered input) route_in shows pad_in as captured on the last rising edge of the selected I/O clock: ioclk0 when the cell's cfg_clksel bit is 0, and ioclk1 when it is 1.
- R3: In mode code 2 (latched input) route_in follows pad_in while the selected I/O clock is high, and holds its value while that clock is low.
- R4: In mode code 3 (output) pad_out equals core_out whether or not the driver is enabled, and route_in is 0.
- R5: In the driving modes (codes 3 and 4), the 2-bit cfg_oesel field of the cell picks the enable source: 0 is pt_oe, 1 is goe0, 2 is goe1 and 3 is always enabled.
- R6: In mode code 4 (bidirectional) the cell drives like an output, and route_in equals pad_in even while pad_oe is 1.
- R7: While test_oe_n is 0, every pad_oe bit is 0, whatever the modes and enables.
- R8: While prog_hiz is 1, every pad_oe bit is 0, whatever the modes and enables.
- R9: While rst_n is 0, input registers clear on the next rising edge of their clock and latches clear at once, so route_in of registered and latched cells reads 0.
- R10: Cells in input modes (codes 0, 1 and 2) and in the unused codes 5 to 7 never assert pad_oe. The unused codes behave as a combinational input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ioclk0 | input | 1 | First dedicated I/O clock |
| ioclk1 | input | 1 | Second dedicated I/O clock |
| rst_n | input | 1 | Active-low reset of input registers and latches |
| cfg_mode | input | 3*NCELL | Per-cell mode code, 3 bits per cell, cell 0 in the low bits |
| cfg_clksel | input | NCELL | Per-cell I/O clock choice (0 = ioclk0, 1 = ioclk1) |
| cfg_oesel | input | 2*NCELL | Per-cell driver enable source code |
| pt_oe | input | 1 | Product-term enable shared by the group |
| goe0 | input | 1 | Global enable 0 |
| goe1 | input | 1 | Global enable 1 |
| test_oe_n | input | 1 | Active-low test enable; 0 tristates all pins |
| prog_hiz | input | 1 | Programming-mode request; 1 tristates all pins |
| core_out | input | NCELL | Data from the logic to drive on the pins |
| pad_in | input | NCELL | Value seen on each pin |
| pad_out | output | NCELL | Data toward each pin driver |
| pad_oe | output | NCELL | Enable of each pin driver |
| route_in | output | NCELL | Per-cell input value toward the routing bus |

## Verification
The hardest situation to create from the ports is a registered cell on one clock disagreeing with a registered cell on the other clock. The same is true of a latch caught in its hold phase. Both depend on where the two I/O clocks stand relative to each other. The bench therefore derives ioclk1 as a divide-by-four of ioclk0 and waits for a rising edge of ioclk1 before it changes pad_in. This gives a window of one ioclk0 edge in which only the ioclk0 cells have taken the new value. The latch is checked both inside the high phase of ioclk1 and after its falling edge.

// File: rtl/iocg_pkg.sv
// Package: shared encodings for the I/O cell group.
// Assumes mode and enable-source fields are packed per cell, cell 0 lowest.
package iocg_pkg;
    localparam int MODE_W  = 3;
    localparam int OESEL_W = 2;
    localparam int NSRC    = 1 << OESEL_W;

    typedef enum logic [MODE_W-1:0] {
        MODE_COMB  = 3'd0,
        MODE_REG   = 3'd1,
        MODE_LATCH = 3'd2,
        MODE_OUT   = 3'd3,
        MODE_BIDIR = 3'd4
    } iocg_mode_e;

    typedef enum logic [OESEL_W-1:0] {
        OESEL_PT = 2'd0,
        OESEL_G0 = 2'd1,
        OESEL_G1 = 2'd2,
        OESEL_ON = 2'd3
    } iocg_oesel_e;
endpackage

// File: rtl/iocg_oe_gate.sv
// Module: group-wide enable source vector.
// Builds one enable per source code. Each enable is already masked by the
// test enable and by the programming high-impedance request.
// Assumes all control inputs are level signals from outside the block.
module iocg_oe_gate
    import iocg_pkg::*;
(
    input  logic             pt_oe,
    input  logic             goe0,
    input  logic             goe1,
    input  logic             test_oe_n,
    input  logic             prog_hiz,
    output logic [NSRC-1:0]  oe_src
);
    logic allow;

    // Overrides: either forced-off request removes every source
    assign allow = test_oe_n & ~prog_hiz;

    // Source vector indexed by the per-cell select code
    always_comb begin
        oe_src           = '0;
        oe_src[OESEL_PT] = pt_oe & allow;
        oe_src[OESEL_G0] = goe0  & allow;
        oe_src[OESEL_G1] = goe1  & allow;
        oe_src[OESEL_ON] = allow;
    end
endmodule

// File: rtl/iocg_in_capture.sv
// Module: input capture of one cell.
// Holds one register per I/O clock and one level latch that is open while
// the selected clock is high. Reset is synchronous for the registers, and a
// level clear for the latch. Assumes clksel is static while capturing.
module iocg_in_capture (
    input  logic ioclk0,
    input  logic ioclk1,
    input  logic rst_n,
    input  logic clksel,
    input  logic pad_in,
    output logic reg_q,
    output logic lat_q
);
    logic q0;
    logic q1;
    logic lat_en;

    // Capture on the first I/O clock
    always_ff @(posedge ioclk0) begin
        if (!rst_n) q0 <= 1'b0;
        else        q0 <= pad_in;
    end

    // Capture on the second I/O clock
    always_ff @(posedge ioclk1) begin
        if (!rst_n) q1 <= 1'b0;
        else        q1 <= pad_in;
    end

    // Latch is open while the selected clock is high
    assign lat_en = clksel ? ioclk1 : ioclk0;

    // Level latch with reset clear
    always_latch begin
        if (!rst_n)      lat_q <= 1'b0;
        else if (lat_en) lat_q <= pad_in;
    end

    // Registered value from the selected clock domain
    assign reg_q = clksel ? q1 : q0;
endmodule

// File: rtl/iocg_cell.sv
// Module: one configurable I/O cell.
// Decodes the mode, steers the route value and the pin drive, and picks
// its driver enable from the group source vector. Unused codes act as a
// combinational input.
module iocg_cell
    import iocg_pkg::*;
(
    input  logic               ioclk0,
    input  logic               ioclk1,
    input  logic               rst_n,
    input  logic [MODE_W-1:0]  mode,
    input  logic               clksel,
    input  logic [OESEL_W-1:0] oesel,
    input  logic [NSRC-1:0]    oe_src,
    input  logic               core_out,
    input  logic               pad_in,
    output logic               pad_out,
    output logic               pad_oe,
    output logic               route_in
);
    iocg_mode_e mode_e;
    logic       reg_q;
    logic       lat_q;
    logic       drive_en;

    assign mode_e   = iocg_mode_e'(mode);
    assign drive_en = oe_src[oesel];

    iocg_in_capture u_cap (
        .ioclk0 (ioclk0),
        .ioclk1 (ioclk1),
        .rst_n  (rst_n),
        .clksel (clksel),
        .pad_in (pad_in),
        .reg_q  (reg_q),
        .lat_q  (lat_q)
    );

    // Mode decode: route source and pin drive
    always_comb begin
        pad_out  = 1'b0;
        pad_oe   = 1'b0;
        route_in = pad_in;
        case (mode_e)
            MODE_REG:   route_in = reg_q;
            MODE_LATCH: route_in = lat_q;
            MODE_OUT: begin
                pad_out  = core_out;
                pad_oe   = drive_en;
                route_in = 1'b0;
            end
            MODE_BIDIR: begin
                pad_out  = core_out;
                pad_oe   = drive_en;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/iocg_group.sv
// Module: group of NCELL configurable I/O cells.
// Shares one enable-source vector across the group and replicates the
// cell. Assumes the configuration inputs are static during normal use.
module iocg_group
    import iocg_pkg::*;
#(
    parameter int NCELL = 16
) (
    input  logic                     ioclk0,
    input  logic                     ioclk1,
    input  logic                     rst_n,
    input  logic [NCELL*MODE_W-1:0]  cfg_mode,
    input  logic [NCELL-1:0]         cfg_clksel,
    input  logic [NCELL*OESEL_W-1:0] cfg_oesel,
    input  logic                     pt_oe,
    input  logic                     goe0,
    input  logic                     goe1,
    input  logic                     test_oe_n,
    input  logic                     prog_hiz,
    input  logic [NCELL-1:0]         core_out,
    input  logic [NCELL-1:0]         pad_in,
    output logic [NCELL-1:0]         pad_out,
    output logic [NCELL-1:0]         pad_oe,
    output logic [NCELL-1:0]         route_in
);
    logic [NSRC-1:0] oe_src;

    iocg_oe_gate u_oe (
        .pt_oe     (pt_oe),
        .goe0      (goe0),
        .goe1      (goe1),
        .test_oe_n (test_oe_n),
        .prog_hiz  (prog_hiz),
        .oe_src    (oe_src)
    );

    // One cell per pin
    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        iocg_cell u_cell (
            .ioclk0   (ioclk0),
            .ioclk1   (ioclk1),
            .rst_n    (rst_n),
            .mode     (cfg_mode[i*MODE_W +: MODE_W]),
            .clksel   (cfg_clksel[i]),
            .oesel    (cfg_oesel[i*OESEL_W +: OESEL_W]),
            .oe_src   (oe_src),
            .core_out (core_out[i]),
            .pad_in   (pad_in[i]),
            .pad_out  (pad_out[i]),
            .pad_oe   (pad_oe[i]),
            .route_in (route_in[i])
        );
    end
endmodule

// File: rtl/iocg_group_chk.sv
// Module: assertion checker for iocg_group, attached by bind.
// Samples on ioclk0. Assumes the configuration changes only between edges.
module iocg_group_chk
    import iocg_pkg::*;
#(
    parameter int NCELL = 16
) (
    input logic                     ioclk0,
    input logic                     rst_n,
    input logic [NCELL*MODE_W-1:0]  cfg_mode,
    input logic [NCELL-1:0]         cfg_clksel,
    input logic [NCELL*OESEL_W-1:0] cfg_oesel,
    input logic                     test_oe_n,
    input logic                     prog_hiz,
    input logic [NCELL-1:0]         core_out,
    input logic [NCELL-1:0]         pad_in,
    input logic [NCELL-1:0]         pad_out,
    input logic [NCELL-1:0]         pad_oe,
    input logic [NCELL-1:0]         route_in
);
    // R7: test enable low leaves no driver on
    p_test_oe_r7: assert property (@(posedge ioclk0) disable iff (!rst_n)
        !test_oe_n |-> pad_oe == '0);

    // R8: programming request leaves no driver on
    p_prog_hiz_r8: assert property (@(posedge ioclk0) disable iff (!rst_n)
        prog_hiz |-> pad_oe == '0);

    for (genvar i = 0; i < NCELL; i++) begin : g_chk
        logic [MODE_W-1:0]  m;
        logic [OESEL_W-1:0] s;
        assign m = cfg_mode[i*MODE_W +: MODE_W];
        assign s = cfg_oesel[i*OESEL_W +: OESEL_W];

        // R1: combinational input passes the pin
        p_comb_pass_r1: assert property (@(posedge ioclk0) disable iff (!rst_n)
            (m == 3'd0) |-> route_in[i] == pad_in[i]);

        // R2: registered input on ioclk0 shows the previous pin value
        p_reg_capture_r2: assert property (@(posedge ioclk0) disable iff (!rst_n)
            ($past(rst_n) && m == 3'd1 && $past(m) == 3'd1 &&
             !cfg_clksel[i] && !$past(cfg_clksel[i]))
            |-> route_in[i] == $past(pad_in[i]));

        // R4: output mode routes 0 and presents core data
        p_out_route_r4: assert property (@(posedge ioclk0) disable iff (!rst_n)
            (m == 3'd3) |-> (route_in[i] == 1'b0 && pad_out[i] == core_out[i]));

        // R5: always-on source enables the driver when not overridden
        p_oesel_on_r5: assert property (@(posedge ioclk0) disable iff (!rst_n)
            ((m == 3'd3 || m == 3'd4) && s == 2'd3 && test_oe_n && !prog_hiz)
            |-> pad_oe[i]);

        // R6: bidirectional cell always feeds back its pin
        p_bidir_feedback_r6: assert property (@(posedge ioclk0) disable iff (!rst_n)
            (m == 3'd4) |-> route_in[i] == pad_in[i]);

        // R10: non-driving codes never enable the driver
        p_input_no_drive_r10: assert property (@(posedge ioclk0) disable iff (!rst_n)
            (m != 3'd3 && m != 3'd4) |-> !pad_oe[i]);
    end
endmodule

bind iocg_group iocg_group_chk #(.NCELL(NCELL)) u_chk (
    .ioclk0     (ioclk0),
    .rst_n      (rst_n),
    .cfg_mode   (cfg_mode),
    .cfg_clksel (cfg_clksel),
    .cfg_oesel  (cfg_oesel),
    .test_oe_n  (test_oe_n),
    .prog_hiz   (prog_hiz),
    .core_out   (core_out),
    .pad_in     (pad_in),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .route_in   (route_in)
);

// File: tb/iocg_group_test.sv
`timescale 1ns/1ps
module iocg_group_test;
    localparam int N  = 16;
    localparam int NV = 15;
    // Vector fields: [16:13] req, [12:10] mode, [9:8] oesel,
    // [7:3] pt_oe goe0 goe1 test_oe_n prog_hiz, [2:0] exp_oe exp_route_pad exp_out_core
    localparam logic [16:0] VEC [NV] = '{
        {4'd1,  3'd0, 2'd3, 5'b11110, 3'b010},  // R1 comb input, no drive
        {4'd4,  3'd3, 2'd0, 5'b10010, 3'b101},  // R4 output, pt enable on
        {4'd5,  3'd3, 2'd0, 5'b01110, 3'b001},  // R5 pt source off
        {4'd5,  3'd3, 2'd1, 5'b01010, 3'b101},  // R5 goe0 source on
        {4'd5,  3'd3, 2'd1, 5'b10110, 3'b001},  // R5 goe0 source off
        {4'd5,  3'd3, 2'd2, 5'b00110, 3'b101},  // R5 goe1 source on
        {4'd5,  3'd3, 2'd2, 5'b11010, 3'b001},  // R5 goe1 source off
        {4'd5,  3'd3, 2'd3, 5'b00010, 3'b101},  // R5 always on
        {4'd7,  3'd3, 2'd3, 5'b11100, 3'b001},  // R7 test enable low
        {4'd8,  3'd3, 2'd3, 5'b11111, 3'b001},  // R8 programming request
        {4'd6,  3'd4, 2'd0, 5'b10010, 3'b111},  // R6 bidir driving, feedback
        {4'd6,  3'd4, 2'd3, 5'b00000, 3'b011},  // R6 bidir forced off
        {4'd10, 3'd5, 2'd3, 5'b11110, 3'b010},  // R10 unused code 5
        {4'd10, 3'd7, 2'd3, 5'b11110, 3'b010},  // R10 unused code 7
        {4'd8,  3'd4, 2'd1, 5'b01011, 3'b011}   // R8 bidir with request
    };

    logic ioclk0 = 1'b0;
    logic ioclk1;
    logic [1:0] div = '0;
    logic rst_n = 1'b0;
    logic [3*N-1:0] cfg_mode = '0;
    logic [N-1:0]   cfg_clksel = '0;
    logic [2*N-1:0] cfg_oesel = '0;
    logic pt_oe = 1'b0, goe0 = 1'b0, goe1 = 1'b0, test_oe_n = 1'b1, prog_hiz = 1'b0;
    logic [N-1:0] core_out = '0, pad_in = '0;
    logic [N-1:0] pad_out, pad_oe, route_in;
    int tests = 0, fails = 0;
    logic done = 1'b0;

    always #4 ioclk0 = ~ioclk0;
    always_ff @(posedge ioclk0) div <= div + 2'd1;
    assign ioclk1 = div[1];

    iocg_group #(.NCELL(N)) uut (
        .ioclk0(ioclk0), .ioclk1(ioclk1), .rst_n(rst_n),
        .cfg_mode(cfg_mode), .cfg_clksel(cfg_clksel), .cfg_oesel(cfg_oesel),
        .pt_oe(pt_oe), .goe0(goe0), .goe1(goe1), .test_oe_n(test_oe_n),
        .prog_hiz(prog_hiz), .core_out(core_out), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .route_in(route_in)
    );

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge ioclk0);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R9 reset state: even cells registered, odd cells latched
        for (int i = 0; i < N; i++) cfg_mode[i*3 +: 3] = (i % 2 == 0) ? 3'd1 : 3'd2;
        pad_in = 16'hFFFF;
        repeat (6) @(negedge ioclk0);
        #1 chk("R9 route in reset", {32'h0, route_in}, 48'h0);
        chk("R9 no drive in reset", {32'h0, pad_oe}, 48'h0);
        rst_n = 1'b1;

        // Vector table over the combinational paths
        for (int v = 0; v < NV; v++) begin
            logic [16:0] e;
            e = VEC[v];
            @(negedge ioclk0);
            cfg_mode  = {N{e[12:10]}};
            cfg_oesel = {N{e[9:8]}};
            {pt_oe, goe0, goe1, test_oe_n, prog_hiz} = e[7:3];
            pad_in   = 16'hA5C3 ^ 16'(v * 16'h1111);
            core_out = 16'h3C96 + 16'(v);
            #1 chk($sformatf("R%0d vec %0d", e[16:13], v),
                   {pad_oe, route_in, pad_out},
                   {{N{e[2]}}, e[1] ? pad_in : 16'h0, e[0] ? core_out : 16'h0});
        end
        test_oe_n = 1'b1; prog_hiz = 1'b0;

        // R2 registered input: even cells on ioclk0, odd cells on ioclk1
        @(negedge ioclk0);
        cfg_mode = {N{3'd1}};
        cfg_clksel = 16'hAAAA;
        pad_in = 16'h1234;
        @(posedge ioclk1);
        @(negedge ioclk0);
        pad_in = 16'hFEDC;
        @(negedge ioclk0);
        #1 chk("R2 ioclk0 cells captured, ioclk1 cells held", {32'h0, route_in},
               {32'h0, (16'hFEDC & 16'h5555) | (16'h1234 & 16'hAAAA)});
        @(posedge ioclk1);
        @(negedge ioclk0);
        #1 chk("R2 all cells captured", {32'h0, route_in}, {32'h0, 16'hFEDC});

        // R9 synchronous clear of registered cells
        rst_n = 1'b0;
        @(posedge ioclk1);
        @(negedge ioclk0);
        #1 chk("R9 registers cleared", {32'h0, route_in}, 48'h0);
        rst_n = 1'b1;

        // R3 latched input on ioclk1
        @(negedge ioclk0);
        cfg_mode = {N{3'd2}};
        cfg_clksel = 16'hFFFF;
        @(posedge ioclk1);
        @(negedge ioclk0);
        pad_in = 16'h5A5A;
        #1 chk("R3 latch transparent", {32'h0, route_in}, {32'h0, 16'h5A5A});
        @(negedge ioclk1);
        @(negedge ioclk0);
        pad_in = 16'h0F0F;
        #1 chk("R3 latch holds", {32'h0, route_in}, {32'h0, 16'h5A5A});
        rst_n = 1'b0;
        #1 chk("R9 latch cleared", {32'h0, route_in}, 48'h0);
        @(negedge ioclk0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule